// File: doc/BRIEF.md
# Pipeline General-Purpose Register File with Writeback Decode

This block is the general-purpose register store of a five-stage load/store pipeline: 32 registers of 32 bits each. Two read ports take their addresses straight from the instruction sitting in the decode stage. A single write port is steered by the instruction in the writeback stage. The block decodes that writeback instruction on its own. It classifies the opcode, chooses which destination field applies, and selects either the loaded memory word or the ALU result as the data to write.

Within a single cycle the write is ordered ahead of the reads. A decode-stage instruction that reads a register being written in the same cycle therefore sees the new value, and the pipeline needs no extra bypass for the writeback-to-decode distance.

Register 0 always reads zero and drops any write to it. As a result the all-zero instruction works as a bubble in either stage. Fetch, the ALU and the data memory sit outside this block; their results arrive on input ports.

Top module: `gpr_file`

## Requirements
- R1: After the active-low asynchronous reset, every register reads zero on both ports.
- R2: Bit 31 of an instruction is its leftmost bit. Read port A is addressed by instr[25:21] of the decode instruction and port B by instr[20:16]. Both read paths are combinational.
- R3: The opcode is instr[31:26]. With the default parameters, 0x00 is register-type, 0x23 is load, 0x2B is store, 0x04 is branch and 0x02 is jump. Every other opcode is an immediate-type ALU operation.
- R4: A register-type writeback instruction writes the ALU result to the register named by instr[15:11].
- R5: An immediate-type ALU writeback instruction writes the ALU result to the register named by instr[20:16].
- R6: A load writeback instruction writes the load data, not the ALU result, to the register named by instr[20:16].
- R7: Store, branch and jump writeback instructions change no register.
- R8: When a write and a read target the same register in one cycle, the read port returns the value being written. This holds on both ports.
- R9: Register 0 reads zero at all times, and writes addressed to it have no effect.
- R10: A written value is held and returned by later reads until that register is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_instr_i | input | 32 | Decode-stage instruction; supplies both read addresses |
| wb_instr_i | input | 32 | Writeback-stage instruction; supplies opcode and destination |
| wb_alu_i | input | 32 | ALU result carried with the writeback instruction |
| wb_load_i | input | 32 | Memory data carried with the writeback instruction |
| rd_a_o | output | 32 | Read data, port A |
| rd_b_o | output | 32 | Read data, port B |

## Verification
The assertions check the following on every cycle:
- register 0 returns zero on both ports;
- a same-cycle write to a read address is forwarded to that port;
- a value written in one cycle is returned in the next unless it is overwritten;
- a jump never enables the write;
- a load always selects the memory word;
- a register-type instruction always takes its destination from instr[15:11].

Some behaviour can only be shown by the bench's scenarios:
- the reset contents of all 32 registers;
- the full opcode classification, including the no-write classes and immediate-type destinations;
- long-term retention across interleaved traffic;
- that data carried by non-writing instructions never leaks into any register.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int INSTR_W = 32;
  localparam int AW      = 5;
  localparam int NREGS   = 1 << AW;
  localparam int OPC_W   = 6;

  typedef enum logic [2:0] {
    CLS_ALU_R,
    CLS_LOAD,
    CLS_STORE,
    CLS_ALU_I,
    CLS_BRANCH,
    CLS_JUMP
  } instr_cls_e;

  typedef enum logic {SRC_ALU, SRC_MEM} wb_src_e;

  function automatic logic [OPC_W-1:0] opc_of(input logic [INSTR_W-1:0] ins);
    return ins[31:26];
  endfunction
  function automatic logic [AW-1:0] src_a_of(input logic [INSTR_W-1:0] ins);
    return ins[25:21];
  endfunction
  function automatic logic [AW-1:0] src_b_of(input logic [INSTR_W-1:0] ins);
    return ins[20:16];
  endfunction
  function automatic logic [AW-1:0] dst_r_of(input logic [INSTR_W-1:0] ins);
    return ins[15:11];
  endfunction
endpackage

// File: rtl/gpr_wb_decode.sv
module gpr_wb_decode
  import gpr_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [OPC_W-1:0]  OP_R      = 6'h00,
  parameter logic [OPC_W-1:0]  OP_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0]  OP_STORE  = 6'h2B,
  parameter logic [OPC_W-1:0]  OP_BRANCH = 6'h04,
  parameter logic [OPC_W-1:0]  OP_JUMP   = 6'h02
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  alu_i,
  input  logic [DATA_W-1:0]  load_i,
  output instr_cls_e         cls_o,
  output logic               we_o,
  output logic [AW-1:0]      dest_o,
  output logic [DATA_W-1:0]  data_o
);
  localparam int NCLS = 5;
  localparam logic [NCLS-1:0][OPC_W-1:0] OPC_TBL = {OP_JUMP, OP_BRANCH, OP_STORE, OP_LOAD, OP_R};
  localparam instr_cls_e CLS_TBL [NCLS] = '{CLS_ALU_R, CLS_LOAD, CLS_STORE, CLS_BRANCH, CLS_JUMP};

  logic [NCLS-1:0] hit;
  wb_src_e         src;

  for (genvar k = 0; k < NCLS; k++) begin : g_match
    assign hit[k] = (opc_of(instr_i) == OPC_TBL[k]);
  end

  // Lowest table index wins if parameters ever alias.
  always_comb begin
    cls_o = CLS_ALU_I;
    for (int k = NCLS - 1; k >= 0; k--) begin
      if (hit[k]) cls_o = CLS_TBL[k];
    end
  end

  always_comb begin
    we_o   = 1'b0;
    dest_o = src_b_of(instr_i);
    src    = SRC_ALU;
    unique case (cls_o)
      CLS_ALU_R: begin we_o = 1'b1; dest_o = dst_r_of(instr_i); end
      CLS_ALU_I: we_o = 1'b1;
      CLS_LOAD:  begin we_o = 1'b1; src = SRC_MEM; end
      default:   we_o = 1'b0;
    endcase
    if (dest_o == '0) we_o = 1'b0;
  end

  assign data_o = (src == SRC_MEM) ? load_i : alu_i;
endmodule

// File: rtl/gpr_regs.sv
module gpr_regs
  import gpr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_RD-1:0][AW-1:0]      raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);
  logic [NREGS-1:0][DATA_W-1:0] mem_q;

  assign mem_q[0] = '0;

  for (genvar r = 1; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[r] <= '0;
      else if (we_i && waddr_i == AW'(r))     mem_q[r] <= wdata_i;
    end
  end

  // Write-first: forward the pending write to a matching read.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      if (we_i && waddr_i == raddr_i[p] && raddr_i[p] != '0) rdata_o[p] = wdata_i;
      else                                                     rdata_o[p] = mem_q[raddr_i[p]];
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter logic [OPC_W-1:0] OP_R      = 6'h00,
  parameter logic [OPC_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OPC_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OPC_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        id_instr_i,
  input  logic [31:0]        wb_instr_i,
  input  logic [DATA_W-1:0]  wb_alu_i,
  input  logic [DATA_W-1:0]  wb_load_i,
  output logic [DATA_W-1:0]  rd_a_o,
  output logic [DATA_W-1:0]  rd_b_o
);
  localparam int NUM_RD = 2;

  instr_cls_e                    wb_cls;
  logic                          wb_we;
  logic [AW-1:0]                 wb_dest;
  logic [DATA_W-1:0]             wb_data;
  logic [NUM_RD-1:0][AW-1:0]     raddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rdata;

  gpr_wb_decode #(
    .DATA_W(DATA_W), .OP_R(OP_R), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_dec (
    .instr_i (wb_instr_i),
    .alu_i   (wb_alu_i),
    .load_i  (wb_load_i),
    .cls_o   (wb_cls),
    .we_o    (wb_we),
    .dest_o  (wb_dest),
    .data_o  (wb_data)
  );

  assign raddr[0] = src_a_of(id_instr_i);
  assign raddr[1] = src_b_of(id_instr_i);

  gpr_regs #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_we),
    .waddr_i (wb_dest),
    .wdata_i (wb_data),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign rd_a_o = rdata[0];
  assign rd_b_o = rdata[1];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
  import gpr_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter logic [OPC_W-1:0] OP_R    = 6'h00,
  parameter logic [OPC_W-1:0] OP_LOAD = 6'h23,
  parameter logic [OPC_W-1:0] OP_JUMP = 6'h02
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       id_instr_i,
  input logic [31:0]       wb_instr_i,
  input logic [DATA_W-1:0] wb_load_i,
  input logic [DATA_W-1:0] rd_a_o,
  input logic [DATA_W-1:0] rd_b_o,
  input logic              we_i,
  input logic [AW-1:0]     dest_i,
  input logic [DATA_W-1:0] wdata_i
);
  logic [AW-1:0] ra, rb;
  assign ra = id_instr_i[25:21];
  assign rb = id_instr_i[20:16];

  assert_zero_reg_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra == '0) |-> (rd_a_o == '0));
  assert_zero_reg_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb == '0) |-> (rd_b_o == '0));

  assert_fwd_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dest_i == ra) |-> (rd_a_o == wdata_i));
  assert_fwd_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dest_i == rb) |-> (rd_b_o == wdata_i));

  assert_hold_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((ra == $past(dest_i) && !(we_i && dest_i == ra)) ? (rd_a_o == $past(wdata_i)) : 1'b1));

  assert_jump_no_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_instr_i[31:26] == OP_JUMP) |-> !we_i);

  assert_load_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wb_instr_i[31:26] == OP_LOAD) |-> (wdata_i == wb_load_i));

  assert_rtype_dest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wb_instr_i[31:26] == OP_R) |-> (dest_i == wb_instr_i[15:11]));
endmodule

bind gpr_file gpr_file_chk #(
  .DATA_W(DATA_W), .OP_R(OP_R), .OP_LOAD(OP_LOAD), .OP_JUMP(OP_JUMP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .id_instr_i (id_instr_i),
  .wb_instr_i (wb_instr_i),
  .wb_load_i  (wb_load_i),
  .rd_a_o     (rd_a_o),
  .rd_b_o     (rd_b_o),
  .we_i       (wb_we),
  .dest_i     (wb_dest),
  .wdata_i    (wb_data)
);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_instr = '0, wb_instr = '0, wb_alu = '0, wb_load = '0;
  logic [31:0] rd_a, rd_b;

  always #5 clk = ~clk;

  gpr_file u_gpr_file (
    .clk_i(clk), .rst_ni(rst_n), .id_instr_i(id_instr), .wb_instr_i(wb_instr),
    .wb_alu_i(wb_alu), .wb_load_i(wb_load), .rd_a_o(rd_a), .rd_b_o(rd_b)
  );

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] model [32];
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  function automatic logic [31:0] r_ins(input int ra, rb, rd);
    return {6'h00, 5'(ra), 5'(rb), 5'(rd), 11'h0};
  endfunction
  function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, rt);
    return {op, 5'(rs), 5'(rt), 16'hBEEF};
  endfunction
  function automatic logic [31:0] rd_ins(input int ra, rb);
    return {6'h00, 5'(ra), 5'(rb), 16'h0};
  endfunction

  // Reference writeback per R3..R7, R9.
  task automatic wb_ref(input logic [31:0] ins, alu, ld, output bit we,
                        output int d, output logic [31:0] v);
    logic [5:0] op = ins[31:26];
    we = 1; v = alu; d = int'(ins[20:16]);
    if (op == 6'h00)      d = int'(ins[15:11]);
    else if (op == 6'h23) v = ld;
    else if (op == 6'h2B || op == 6'h04 || op == 6'h02) we = 0;
    if (d == 0) we = 0;
  endtask

  task automatic step(input logic [31:0] id, wb, alu, ld, input string tag);
    item_t it;
    bit we; int d; logic [31:0] v; int ra, rb;
    @(negedge clk);
    id_instr = id; wb_instr = wb; wb_alu = alu; wb_load = ld;
    wb_ref(wb, alu, ld, we, d, v);
    ra = int'(id[25:21]); rb = int'(id[20:16]);
    it.exp_a = (we && d == ra) ? v : model[ra];
    it.exp_b = (we && d == rb) ? v : model[rb];
    it.tag = tag;
    sb.push_back(it);
    if (we) model[d] = v;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_chk += 2;
        if (rd_a !== it.exp_a) begin
          n_bad++;
          $display("FAIL %s port A: actual %h expected %h", it.tag, rd_a, it.exp_a);
        end
        if (rd_b !== it.exp_b) begin
          n_bad++;
          $display("FAIL %s port B: actual %h expected %h", it.tag, rd_b, it.exp_b);
        end
      end
    end
  end

  initial begin : watchdog
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] lfsr = 32'hACE1_2345;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents, R2 port addressing
    for (int i = 0; i < 32; i++) step(rd_ins(i, 31 - i), '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");

    // R4 with R8: register-type writes seen in the same cycle on both ports
    for (int i = 1; i < 32; i++)
      step(rd_ins(i, i), r_ins(3, 4, i), 32'h1000_0000 + 32'(i * 7), 32'hDEAD_0000, "R8");

    // R10, R2: read back every register
    for (int i = 0; i < 32; i++) step(rd_ins(i, (i + 5) % 32), '0, '0, '0, "R10");

    // R5: immediate ALU op writes rt, not the rd field position
    step(rd_ins(9, 10), i_ins(6'h08, 3, 9), 32'h0000_0A5A, 32'h5555_5555, "R5");
    step(rd_ins(9, 10), '0, '0, '0, "R5");
    // R6: load writes memory data
    step(rd_ins(12, 11), i_ins(6'h23, 2, 11), 32'h0BAD_0BAD, 32'hC0FF_EE00, "R6");
    step(rd_ins(11, 12), '0, '0, '0, "R6");

    // R7: store, branch, jump change nothing (same cycle and after)
    step(rd_ins(14, 15), i_ins(6'h2B, 1, 14), 32'h1111_1111, 32'h2222_2222, "R7");
    step(rd_ins(15, 16), i_ins(6'h04, 1, 15), 32'h3333_3333, 32'h4444_4444, "R7");
    step(rd_ins(16, 17), {6'h02, 26'h3FF_FFFF}, 32'h5555_5555, 32'h6666_6666, "R7");
    step(rd_ins(14, 15), '0, '0, '0, "R7");
    step(rd_ins(16, 17), '0, '0, '0, "R7");

    // R9: writes to register 0 ignored
    step(rd_ins(0, 0), r_ins(1, 2, 0), 32'h7777_7777, '0, "R9");
    step(rd_ins(0, 0), i_ins(6'h23, 1, 0), '0, 32'h8888_8888, "R9");
    step(rd_ins(0, 1), i_ins(6'h08, 1, 0), 32'h9999_9999, '0, "R9");

    // R3: mixed traffic across all classes
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      logic [31:0] wbi;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1: op = 6'h00;
        3'd2:       op = 6'h23;
        3'd3:       op = 6'h2B;
        3'd4:       op = 6'h04;
        3'd5:       op = 6'h02;
        default:    op = {lfsr[8:4], 1'b1};
      endcase
      wbi = {op, lfsr[13:9], lfsr[18:14], lfsr[23:19], lfsr[30:20]};
      step({lfsr[31:26], lfsr[7:3], lfsr[12:8], 16'h0}, wbi,
           lfsr ^ 32'h5A5A_5A5A, ~lfsr, "R3");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule